// File: doc/BRIEF.md
# Windowed Frame Statistics Accumulator

The block observes an RGB pixel stream and, for every frame, gathers exposure and white-balance figures over a rectangular region of interest. It tracks the position of each pixel itself: a start-of-frame marker places the pixel at column 0, row 0, and an end-of-line marker moves the next pixel to the start of the following row. Two corner registers bound the region. Both corners lie inside it, and the corners may be given in either order.

Over the region it sums R, G, B and R+G+B. It also counts pixels whose R+G+B passes an over-exposure limit, and pixels whose individual channel passes a saturation limit, with one count per channel. When the next frame begins, the totals of the finished frame are copied into read-only result registers and a one-cycle `stats_ready` pulse is raised. Software reads the totals of the last complete frame at any time through a small synchronous-write, combinational-read register port.

Top module: `frame_stats`

## Requirements
- R1: After reset all result registers and both corner registers read 0 and `stats_ready` is low.
- R2: The register port uses word addresses. Address 0 holds corner A and address 1 holds corner B. In each corner, bits 31:16 are the column and bits 15:0 are the row. Both corners are writable and read back what was written. Addresses 2 to 9 are read-only results in this order: R+G+B sum, over-exposed count, R sum, G sum, B sum, R saturated count, G saturated count, B saturated count. Writes to addresses 2 to 9 have no effect. Any other address reads 0.
- R3: A pixel is inside the region when its column lies between the two corner columns and its row lies between the two corner rows, both bounds included.
- R4: Corners given in reverse order (A larger than B on either axis) describe the same region as when they are swapped.
- R5: For each pixel inside the region, the R+G+B sum grows by R+G+B, and each channel sum grows by its own channel value.
- R6: The over-exposed count grows by one for each pixel inside the region whose R+G+B is strictly greater than 12000.
- R7: Each channel's saturated count grows by one for each pixel inside the region whose value in that channel is strictly greater than 4000.
- R8: A valid pixel flagged start-of-frame, when it follows an earlier frame, copies the totals into the result registers and raises `stats_ready` for exactly the next cycle. Between copies, reads return the totals of the previous frame. Accumulation restarts with this pixel.
- R9: A change to a corner register affects only frames that begin after the write.
- R10: Every total saturates at its all-ones value and never wraps.
- R11: Cycles with `pix_valid` low, and pixels that arrive before the first start-of-frame, change no total.
- R12: A start-of-frame pixel is at column 0, row 0. Each valid pixel moves the column forward by one. A valid pixel flagged end-of-line sends the next pixel to column 0 of the next row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel qualifier |
| pix_sof | input | 1 | First pixel of a frame |
| pix_eol | input | 1 | Last pixel of a line |
| pix_r | input | CW | Red component |
| pix_g | input | CW | Green component |
| pix_b | input | CW | Blue component |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| stats_ready | output | 1 | One-cycle pulse when new results are available |

## Verification
A start-of-frame pixel does two things in the same cycle. It closes the old frame, copying the totals and pulsing `stats_ready`, and it opens the new frame, loading the corner shadow and counting itself under the new corners. The bench provokes this by writing reversed corners in the middle of a frame. It also sends frames of a single pixel, so that one start-of-frame follows another. The bench judges the result on every clock by comparing the ready pulse and the rotating register read against a behavioural model. That model applies the pixel under the old shadow before it applies the write. The bench also uses a narrow total width, so that saturation is reached within the same frames that cross the 4000 and 12000 limits.

// File: rtl/frame_stats.sv
module frame_stats #(
  parameter int CW      = 12,
  parameter int SUM_W   = 32,
  parameter int SAT_TH  = 4000,
  parameter int OVER_TH = 12000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic          pix_sof,
  input  logic          pix_eol,
  input  logic [CW-1:0] pix_r,
  input  logic [CW-1:0] pix_g,
  input  logic [CW-1:0] pix_b,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          stats_ready
);
  localparam int NACC = 8;
  localparam int IW   = CW + 2;
  localparam int PW   = 16;
  localparam logic [SUM_W-1:0] MAXV = {SUM_W{1'b1}};

  logic [31:0]      corner_a, corner_b, shad_a, shad_b;
  logic [PW-1:0]    xc, yc;
  logic             running;
  logic [SUM_W-1:0] acc [NACC];
  logic [SUM_W-1:0] res [NACC];
  logic [IW-1:0]    inc [NACC];

  wire          start  = pix_valid && pix_sof;
  wire [31:0]   win_a  = pix_sof ? corner_a : shad_a;
  wire [31:0]   win_b  = pix_sof ? corner_b : shad_b;
  wire [PW-1:0] ax = win_a[31:16], bx = win_b[31:16];
  wire [PW-1:0] ay = win_a[15:0],  by = win_b[15:0];
  wire [PW-1:0] x_lo = (ax < bx) ? ax : bx;
  wire [PW-1:0] x_hi = (ax < bx) ? bx : ax;
  wire [PW-1:0] y_lo = (ay < by) ? ay : by;
  wire [PW-1:0] y_hi = (ay < by) ? by : ay;
  wire [PW-1:0] cur_x = pix_sof ? '0 : xc;
  wire [PW-1:0] cur_y = pix_sof ? '0 : yc;
  wire in_win = pix_valid && (pix_sof || running) &&
                cur_x >= x_lo && cur_x <= x_hi && cur_y >= y_lo && cur_y <= y_hi;
  wire [IW-1:0] sum3 = IW'(pix_r) + IW'(pix_g) + IW'(pix_b);

  always_comb begin
    inc[0] = sum3;
    inc[1] = IW'(sum3 > IW'(OVER_TH));
    inc[2] = IW'(pix_r);
    inc[3] = IW'(pix_g);
    inc[4] = IW'(pix_b);
    inc[5] = IW'(pix_r > CW'(SAT_TH));
    inc[6] = IW'(pix_g > CW'(SAT_TH));
    inc[7] = IW'(pix_b > CW'(SAT_TH));
  end

  function automatic logic [SUM_W-1:0] sat_add(input logic [SUM_W-1:0] a, input logic [IW-1:0] b);
    logic [SUM_W:0] s;
    s = {1'b0, a} + (SUM_W+1)'(b);
    return s[SUM_W] ? MAXV : s[SUM_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      corner_a <= '0; corner_b <= '0;
      shad_a <= '0;   shad_b <= '0;
      xc <= '0; yc <= '0;
      running <= 1'b0;
      stats_ready <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == 4'd0) corner_a <= reg_wdata;
      if (reg_wr && reg_addr == 4'd1) corner_b <= reg_wdata;
      stats_ready <= start && running;
      if (start) begin
        shad_a <= corner_a;
        shad_b <= corner_b;
        running <= 1'b1;
      end
      if (pix_valid) begin
        xc <= pix_eol ? '0 : cur_x + 1'b1;
        yc <= pix_eol ? cur_y + 1'b1 : cur_y;
      end
    end
  end

  for (genvar i = 0; i < NACC; i++) begin : g_acc
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc[i] <= '0;
        res[i] <= '0;
      end else begin
        if (start) acc[i] <= in_win ? SUM_W'(inc[i]) : '0;
        else if (in_win) acc[i] <= sat_add(acc[i], inc[i]);
        if (start && running) res[i] <= acc[i];
      end
    end

    p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !pix_sof) |=> acc[i] >= $past(acc[i]));
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> $stable(acc[i]));
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !stats_ready |-> $stable(res[i]));
  end

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = corner_a;
      4'd1:    reg_rdata = corner_b;
      4'd2:    reg_rdata = 32'(res[0]);
      4'd3:    reg_rdata = 32'(res[1]);
      4'd4:    reg_rdata = 32'(res[2]);
      4'd5:    reg_rdata = 32'(res[3]);
      4'd6:    reg_rdata = 32'(res[4]);
      4'd7:    reg_rdata = 32'(res[5]);
      4'd8:    reg_rdata = 32'(res[6]);
      4'd9:    reg_rdata = 32'(res[7]);
      default: reg_rdata = '0;
    endcase
  end

  p_ready_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stats_ready |-> $past(pix_valid && pix_sof));
  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_valid && pix_sof) |=> ($stable(shad_a) && $stable(shad_b)));
endmodule

// File: tb/sim_frame_stats.sv
module sim_frame_stats;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int SW = 16;
  localparam longint MAXV = (64'd1 << SW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pix_valid = 0, pix_sof = 0, pix_eol = 0;
  logic [CW-1:0] pix_r = '0, pix_g = '0, pix_b = '0;
  logic reg_wr = 0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic stats_ready;

  frame_stats #(.CW(CW), .SUM_W(SW)) u0 (
    .clk, .rst_n, .pix_valid, .pix_sof, .pix_eol, .pix_r, .pix_g, .pix_b,
    .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .stats_ready);

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  longint m_ca = 0, m_cb = 0, m_sa = 0, m_sb = 0;
  longint m_acc [8];
  longint m_res [8];
  longint m_x = 0, m_y = 0;
  bit m_run = 0, m_rdy = 0;
  int vals [6] = '{100, 4000, 4001, 4095, 0, 2500};

  function automatic string tag_of(int a);
    case (a)
      0, 1: return "R2";
      3: return "R6";
      7, 8, 9: return "R7";
      10, 11, 12, 13, 14, 15: return "R2";
      default: return "R5";
    endcase
  endfunction

  function automatic longint exp_read(int a);
    if (a == 0) return m_ca;
    if (a == 1) return m_cb;
    if (a >= 2 && a <= 9) return m_res[a-2];
    return 0;
  endfunction

  function automatic longint lo16(longint a, longint b);
    return (a < b) ? a : b;
  endfunction
  function automatic longint hi16(longint a, longint b);
    return (a < b) ? b : a;
  endfunction

  task automatic model_reset();
    m_ca = 0; m_cb = 0; m_sa = 0; m_sb = 0; m_x = 0; m_y = 0;
    m_run = 0; m_rdy = 0;
    foreach (m_acc[i]) begin m_acc[i] = 0; m_res[i] = 0; end
  endtask

  task automatic model_step();
    longint px, py, sa, sb, s3;
    longint inc [8];
    bit inw;
    m_rdy = 0;
    if (pix_valid) begin
      if (pix_sof) begin
        if (m_run) begin
          foreach (m_res[i]) m_res[i] = m_acc[i];
          m_rdy = 1;
        end
        m_run = 1; m_sa = m_ca; m_sb = m_cb; px = 0; py = 0;
        foreach (m_acc[i]) m_acc[i] = 0;
      end else begin
        px = m_x; py = m_y;
      end
      sa = m_sa; sb = m_sb;
      inw = m_run &&
            px >= lo16(sa >> 16, sb >> 16) && px <= hi16(sa >> 16, sb >> 16) &&
            py >= lo16(sa & 16'hFFFF, sb & 16'hFFFF) && py <= hi16(sa & 16'hFFFF, sb & 16'hFFFF);
      s3 = longint'(pix_r) + longint'(pix_g) + longint'(pix_b);
      inc[0] = s3; inc[1] = (s3 > 12000);
      inc[2] = pix_r; inc[3] = pix_g; inc[4] = pix_b;
      inc[5] = (pix_r > 4000); inc[6] = (pix_g > 4000); inc[7] = (pix_b > 4000);
      if (inw) foreach (m_acc[i]) begin
        m_acc[i] = m_acc[i] + inc[i];
        if (m_acc[i] > MAXV) m_acc[i] = MAXV;
      end
      if (pix_eol) begin m_x = 0; m_y = py + 1; end
      else begin m_x = px + 1; m_y = py; end
    end
    if (reg_wr && reg_addr == 0) m_ca = reg_wdata;
    if (reg_wr && reg_addr == 1) m_cb = reg_wdata;
  endtask

  task automatic tick(string ctx);
    longint e;
    @(posedge clk);
    if (rst_n) model_step(); else model_reset();
    @(negedge clk);
    cyc++;
    checks++;
    if (stats_ready !== m_rdy) begin
      errors++;
      $display("FAIL R8 [%s] stats_ready actual=%0b expected=%0b", ctx, stats_ready, m_rdy);
    end
    e = exp_read(int'(reg_addr));
    checks++;
    if (longint'(reg_rdata) !== e) begin
      errors++;
      $display("FAIL %s [%s] addr=%0d actual=%0d expected=%0d",
               tag_of(int'(reg_addr)), ctx, reg_addr, reg_rdata, e);
    end
    pix_valid = 0; pix_sof = 0; pix_eol = 0; reg_wr = 0;
    reg_addr = 4'((cyc % 11) + 0);
  endtask

  task automatic write_reg(int a, logic [31:0] d, string ctx);
    reg_wr = 1; reg_addr = 4'(a); reg_wdata = d;
    tick(ctx);
  endtask

  task automatic pixel(int r, int g, int b, bit sof, bit eol, string ctx);
    pix_valid = 1; pix_sof = sof; pix_eol = eol;
    pix_r = CW'(r); pix_g = CW'(g); pix_b = CW'(b);
    tick(ctx);
  endtask

  task automatic send_frame(int w, int h, int mode, int mid_wr, string ctx);
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        int idx, r, g, b;
        idx = (x + y * w) % 6;
        r = vals[idx]; g = vals[(idx + y % 2) % 6]; b = vals[(idx + 2 * (x % 2)) % 6];
        if (mode == 1) begin r = 4095; g = 4095; b = 4095; end
        if (mid_wr != 0 && x == 2 && y == 1) begin
          reg_wr = 1; reg_addr = 0; reg_wdata = {16'd4, 16'd3};
        end
        pixel(r, g, b, x == 0 && y == 0, x == w - 1, ctx);
        if ((x + y) % 3 == 0) tick({ctx, " R11 idle"});
      end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) tick("R1 reset");
    rst_n = 1;
    for (int i = 0; i < 11; i++) tick("R1 after reset");
    // R11: pixels before the first start-of-frame are ignored
    for (int i = 0; i < 4; i++) pixel(4095, 4095, 4095, 0, i == 1, "R11 pre-frame");
    // R2 / R3: inclusive window columns 1..3 rows 1..2
    write_reg(0, {16'd1, 16'd1}, "R2 corner A");
    write_reg(1, {16'd3, 16'd2}, "R2 corner B");
    write_reg(5, 32'hFFFF_FFFF, "R2 result write ignored");
    send_frame(5, 4, 0, 0, "R3 R5 R6 R7 R12 frame1");
    // R4 / R9: reversed corners written mid-frame apply from the next frame only
    send_frame(5, 4, 0, 1, "R9 frame2 old window");
    write_reg(1, {16'd0, 16'd1}, "R4 corner B reversed");
    send_frame(5, 4, 0, 0, "R4 frame3 reversed window");
    for (int i = 0; i < 11; i++) tick("R8 readback");
    // R10: full-range pixels over a full window saturate the narrow totals
    write_reg(0, {16'd0, 16'd0}, "R10 corner A");
    write_reg(1, {16'd4, 16'd3}, "R10 corner B");
    send_frame(5, 4, 1, 0, "R10 saturating frame");
    // R8: back-to-back single-pixel frames
    pixel(4001, 10, 4000, 1, 1, "R8 one-pixel frame a");
    pixel(4095, 4095, 4095, 1, 1, "R8 one-pixel frame b");
    pixel(1, 2, 3, 1, 1, "R8 one-pixel frame c");
    for (int i = 0; i < 11; i++) tick("R8 final readback");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule